// File: doc/BRIEF.md
# Four-Way Set-Associative Translation Buffer

This block caches recent virtual-to-physical page translations for a small paged memory system. A requester presents a 14-bit virtual address and learns in the same cycle whether the buffer holds a translation for it. On a hit the block returns a 12-bit physical address, built from the stored physical page number and the untouched page offset. On a miss the requester fetches the translation elsewhere and installs it through the refill port. A flush input drops every cached translation at once.

Pages are 64 bytes, so the low six address bits pass straight through. The eight-bit virtual page number splits into a two-bit set index (its low bits) and a six-bit tag (its upper bits). The sixteen entries are arranged as four sets of four ways. Each way keeps a valid flag, a tag and a six-bit physical page number.

A refill picks one of three named write actions inside the indexed set. `ACT_UPDATE` is taken when a valid way already carries the same tag, and rewrites that way. `ACT_FILL` is taken when there is no such way but some way is invalid, and writes the lowest-numbered invalid way. `ACT_EVICT` is taken when all four ways are valid and none matches. It replaces the way named by the set's round-robin pointer, then moves that pointer one step forward (way 3 wraps to way 0). No other action moves the pointer.

Top module: `tlb_xlate`

## Requirements
- R1: The set index is `req_vaddr[7:6]` and the tag is `req_vaddr[13:8]`. For a refill, the index is `fill_vpn[1:0]` and the tag is `fill_vpn[7:2]`. Only the indexed set takes part.
- R2: While `req_valid` is high, `hit` is 1 in the same cycle if the indexed set holds a valid way whose tag matches. `paddr` is then that way's page number in bits 11:6, with `req_vaddr[5:0]` in bits 5:0.
- R3: `miss` equals `req_valid` and not `hit`. `paddr` is zero whenever `hit` is 0. With `req_valid` low, both `hit` and `miss` are 0.
- R4: After reset every entry is invalid and every round-robin pointer is at way 0.
- R5: A refill (`fill_en` high) with no matching valid tag and a free way writes the lowest-numbered invalid way. The new translation is visible from the next cycle; a lookup in the refill cycle sees the old contents.
- R6: A refill whose tag matches a valid way in the set rewrites that way's page number, and no duplicate entry is made.
- R7: A refill into a full set with no tag match replaces the way at the set's round-robin pointer. The pointer then advances by one, modulo 4. Flush leaves the pointer unchanged.
- R8: A one-cycle `flush` invalidates all entries from the next cycle. A refill in the same cycle as a flush is dropped.
- R9: Refills into one set leave the translations of the other sets intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request qualifier |
| req_vaddr | input | 14 | Virtual address to translate |
| hit | output | 1 | Translation found (combinational) |
| miss | output | 1 | Request made but no translation found |
| paddr | output | 12 | Translated physical address, zero when no hit |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | 8 | Virtual page number of the translation |
| fill_ppn | input | 6 | Physical page number of the translation |
| flush | input | 1 | Invalidate every entry |

## Verification
Two pairs of functions can share a cycle: a lookup and a refill of the same page, and a refill and a flush. The bench drives a lookup of a page together with the refill that installs it. It expects a miss in that cycle and a hit one cycle later. It also raises a flush together with a refill. A lookup in that cycle must still hit on the old contents, and in the following cycles neither the flushed page nor the page in the dropped refill may hit. A later directed sequence fills a set after the flush. The eviction that follows must land on the way the pointer had reached before the flush, not on way 0.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 14;
    localparam int PA_W   = 12;
    localparam int OFF_W  = 6;
    localparam int SETS   = 4;
    localparam int WAYS   = 4;

    localparam int VPN_W  = VA_W - OFF_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = VPN_W - IDX_W;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);

    // Write action chosen for a refill inside one set
    typedef enum logic [1:0] {
        ACT_UPDATE = 2'd0,
        ACT_FILL   = 2'd1,
        ACT_EVICT  = 2'd2
    } wr_act_e;
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAYS-1:0]  match_i,
    input  logic [WAY_W-1:0] rr_i,
    output wr_act_e          act_o,
    output logic [WAY_W-1:0] way_o
);
    logic [WAY_W-1:0] match_way;
    logic [WAY_W-1:0] free_way;

    // Encode the matching way; at most one can match
    always_comb begin
        match_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_i[w]) match_way = w[WAY_W-1:0];
        end
    end

    // Lowest-numbered invalid way wins: scan from the top down
    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) free_way = w[WAY_W-1:0];
        end
    end

    always_comb begin
        if (|match_i) begin
            act_o = ACT_UPDATE;
            way_o = match_way;
        end else if (!(&valid_i)) begin
            act_o = ACT_FILL;
            way_o = free_way;
        end else begin
            act_o = ACT_EVICT;
            way_o = rr_i;
        end
    end
endmodule

// File: rtl/tlb_set.sv
module tlb_set
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             we_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic [PPN_W-1:0] wr_ppn_i,
    input  logic [TAG_W-1:0] lk_tag_i,
    output logic             lk_hit_o,
    output logic [PPN_W-1:0] lk_ppn_o
);
    logic [WAYS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [WAYS];
    logic [PPN_W-1:0] ppn_q [WAYS];
    logic [WAY_W-1:0] rr_q;

    logic [WAYS-1:0]  lk_match;
    logic [WAYS-1:0]  wr_match;
    wr_act_e          act;
    logic [WAY_W-1:0] wr_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lk_match[w] = valid_q[w] && (tag_q[w] == lk_tag_i);
        assign wr_match[w] = valid_q[w] && (tag_q[w] == wr_tag_i);
    end

    always_comb begin
        lk_ppn_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) lk_ppn_o = lk_ppn_o | ppn_q[w];
        end
    end
    assign lk_hit_o = |lk_match;

    tlb_victim u_victim (
        .valid_i (valid_q),
        .match_i (wr_match),
        .rr_i    (rr_q),
        .act_o   (act),
        .way_o   (wr_way)
    );

    // Valid flags and replacement pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
        end else if (we_i) begin
            valid_q[wr_way] <= 1'b1;
            unique case (act)
                ACT_EVICT:  rr_q <= rr_q + 1'b1;
                ACT_UPDATE,
                ACT_FILL:   rr_q <= rr_q;
                default:    rr_q <= rr_q;
            endcase
        end
    end

    // Entry payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                tag_q[w] <= '0;
                ppn_q[w] <= '0;
            end
        end else if (we_i && !flush_i) begin
            tag_q[wr_way] <= wr_tag_i;
            ppn_q[wr_way] <= wr_ppn_i;
        end
    end

    a_r6_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0));

    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i || act != ACT_EVICT) |=> $stable(rr_q));

    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !flush_i) |=> (valid_q != '0));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            hit,
    output logic            miss,
    output logic [PA_W-1:0] paddr,
    input  logic            fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic            flush
);
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [OFF_W-1:0] lk_off;
    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;

    assign lk_off = req_vaddr[OFF_W-1:0];
    assign lk_idx = req_vaddr[OFF_W +: IDX_W];
    assign lk_tag = req_vaddr[VA_W-1 -: TAG_W];
    assign wr_idx = fill_vpn[IDX_W-1:0];
    assign wr_tag = fill_vpn[VPN_W-1 -: TAG_W];

    logic [SETS-1:0]  set_hit;
    logic [PPN_W-1:0] set_ppn [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic we;
        assign we = fill_en && !flush && (wr_idx == s[IDX_W-1:0]);
        tlb_set u_set (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush_i  (flush),
            .we_i     (we),
            .wr_tag_i (wr_tag),
            .wr_ppn_i (fill_ppn),
            .lk_tag_i (lk_tag),
            .lk_hit_o (set_hit[s]),
            .lk_ppn_o (set_ppn[s])
        );
    end

    always_comb begin
        hit   = req_valid && set_hit[lk_idx];
        miss  = req_valid && !set_hit[lk_idx];
        paddr = hit ? {set_ppn[lk_idx], lk_off} : '0;
    end

    a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!hit && !miss && paddr == '0));

    a_r8_flush_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic        hit, miss;
    logic [11:0] paddr;
    logic        fill_en = 1'b0;
    logic [7:0]  fill_vpn = '0;
    logic [5:0]  fill_ppn = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2ns clk = ~clk;

    tlb_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .hit(hit), .miss(miss), .paddr(paddr), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush)
    );

    typedef struct packed {
        logic        fe;
        logic [7:0]  fvpn;
        logic [5:0]  fppn;
        logic        fl;
        logic        rv;
        logic [13:0] va;
        logic        eh;
        logic        em;
        logic [11:0] ep;
        logic [3:0]  req;
    } vec_t;

    // Set 1 pages: A vpn 3D, B 41, C 45, D 49, E 4D. Lookup sees state before this row's write.
    localparam vec_t VECS [17] = '{
        '{1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F54, 1'b0, 1'b1, 12'h000, 4'd4}, // R4 empty
        '{1'b1, 8'h3D, 6'h0D, 1'b0, 1'b1, 14'h0F54, 1'b0, 1'b1, 12'h000, 4'd5}, // R5 same-cycle old
        '{1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F54, 1'b1, 1'b0, 12'h354, 4'd2}, // R2
        '{1'b1, 8'h41, 6'h11, 1'b0, 1'b0, 14'h0F54, 1'b0, 1'b0, 12'h000, 4'd3}, // R3 idle
        '{1'b1, 8'h45, 6'h22, 1'b0, 1'b1, 14'h107F, 1'b1, 1'b0, 12'h47F, 4'd1}, // R1
        '{1'b1, 8'h49, 6'h33, 1'b0, 1'b1, 14'h0F00, 1'b0, 1'b1, 12'h000, 4'd9}, // R9 other set
        '{1'b1, 8'h3D, 6'h05, 1'b0, 1'b1, 14'h1141, 1'b1, 1'b0, 12'h881, 4'd2}, // R2
        '{1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F54, 1'b1, 1'b0, 12'h154, 4'd6}, // R6 rewrite
        '{1'b1, 8'h4D, 6'h2A, 1'b0, 1'b1, 14'h1242, 1'b1, 1'b0, 12'hCC2, 4'd2}, // R2
        '{1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F54, 1'b0, 1'b1, 12'h000, 4'd7}, // R7 way0 evicted
        '{1'b1, 8'h3D, 6'h06, 1'b0, 1'b1, 14'h1347, 1'b1, 1'b0, 12'hA87, 4'd7}, // R7
        '{1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h107F, 1'b0, 1'b1, 12'h000, 4'd7}, // R7 way1 evicted
        '{1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F54, 1'b1, 1'b0, 12'h194, 4'd7}, // R7
        '{1'b1, 8'h41, 6'h3F, 1'b1, 1'b1, 14'h0F54, 1'b1, 1'b0, 12'h194, 4'd8}, // R8 flush+fill
        '{1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F54, 1'b0, 1'b1, 12'h000, 4'd8}, // R8
        '{1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h107F, 1'b0, 1'b1, 12'h000, 4'd8}, // R8 fill dropped
        '{1'b1, 8'h3D, 6'h01, 1'b0, 1'b1, 14'h0F54, 1'b0, 1'b1, 12'h000, 4'd5}  // R5
    };

    task automatic chk(input string req, input logic eh, input logic em, input logic [11:0] ep);
        checks++;
        if (hit !== eh || miss !== em || paddr !== ep) begin
            errors++;
            $display("FAIL %s: hit=%b miss=%b paddr=%h expected hit=%b miss=%b paddr=%h",
                     req, hit, miss, paddr, eh, em, ep);
        end
    endtask

    task automatic step(input logic fe, input logic [7:0] fv, input logic [5:0] fp,
                        input logic fl, input logic rv, input logic [13:0] va);
        @(negedge clk);
        fill_en = fe; fill_vpn = fv; fill_ppn = fp; flush = fl;
        req_valid = rv; req_vaddr = va;
        #1ns;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 17; i++) begin
            step(VECS[i].fe, VECS[i].fvpn, VECS[i].fppn, VECS[i].fl, VECS[i].rv, VECS[i].va);
            chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].eh, VECS[i].em, VECS[i].ep);
        end

        // R7: pointer kept at way 2 across flush; A sits in way 0
        step(1'b1, 8'h41, 6'h11, 1'b0, 1'b0, 14'h0);
        step(1'b1, 8'h45, 6'h22, 1'b0, 1'b0, 14'h0);
        step(1'b1, 8'h49, 6'h33, 1'b0, 1'b0, 14'h0);
        step(1'b1, 8'h4D, 6'h2A, 1'b0, 1'b0, 14'h0);
        step(1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h1141);
        chk("R7 way2 evicted after flush", 1'b0, 1'b1, 12'h000);
        step(1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F54);
        chk("R7 way0 kept", 1'b1, 1'b0, 12'h054);
        step(1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h107F);
        chk("R7 way1 kept", 1'b1, 1'b0, 12'h47F);
        step(1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h1347);
        chk("R7 new entry", 1'b1, 1'b0, 12'hA87);

        // R9: same tag in set 0 is independent
        step(1'b1, 8'h3C, 6'h3E, 1'b0, 1'b0, 14'h0);
        step(1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F00);
        chk("R9 set0 entry", 1'b1, 1'b0, 12'hF80);
        step(1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F54);
        chk("R9 set1 untouched", 1'b1, 1'b0, 12'h054);

        // R4: reset invalidates everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F54);
        chk("R4 after reset set1", 1'b0, 1'b1, 12'h000);
        step(1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 14'h0F00);
        chk("R4 after reset set0", 1'b0, 1'b1, 12'h000);

        step(1'b0, 8'h00, 6'h00, 1'b0, 1'b0, 14'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule